// File: doc/BRIEF.md
# Acquisition Sample Ring Buffer

This block is a circular store for converter samples. It sits inside a word-addressed memory that a producer and a host share. The conversion engine presents one sample per cycle on a valid/data pair. The block writes each accepted sample at the slot named by its write index, which it calls the front, and then advances the front. The host reads the stored words through the same register port. When it has consumed them, it writes its read position, the rear, back into a register. The ring depth is a parameter whose default, 2003, is not a power of two, so both indices wrap explicitly.

The block computes the pending count from the two indices and compares it with a host-programmable threshold. It also keeps three sticky event flags in the low bits of an eight-bit flag word; the upper bits of that word belong to other subsystems. An eight-bit mask selects which flags drive the single interrupt line. The host clears a flag by writing a one to its bit. A sample that arrives when only one free slot remains is discarded and marks a software overrun. A fault strobe from the converter marks a hardware overrun.

Top module: `acq_ring_buffer`

## Requirements
- R1: After synchronous reset, front, rear, flag word and mask all read 0, the threshold reads DEPTH/2 (1001 for the default depth), and irq is 0.
- R2: An accepted sample is stored at host word address 0x800 + front. The front then increments, wrapping from DEPTH-1 to 0. The front reads at address 0xff9.
- R3: Pending equals front minus rear, plus DEPTH when that difference is negative.
- R4: A sample offered while pending equals DEPTH-1 is dropped: it is not stored, the front does not move, and flag bit 1 (software overrun) is set.
- R5: A one-cycle pulse on conv_fault sets flag bit 2 (hardware overrun).
- R6: The rear register at address 0xffa takes host writes below DEPTH and ignores larger values. Pending reflects the new rear from the next clock on.
- R7: Flag bit 0 is set on every clock edge at which pending is at least the threshold register (address 0xff4, low index-width bits). When a set and a clear reach the same bit in the same cycle, the set wins.
- R8: The flag word at address 0xffc clears bits 0..2 where a one is written. Bits 7..3 always read 0 and ignore writes.
- R9: The mask register at address 0xffb holds 8 bits. irq is the OR of flag AND mask, and a mask of zero holds irq at 0.
- R10: A read request returns data on host_rdata one cycle later. The returned value is the state before that cycle's writes. The storage window is read-only, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Producer offers a sample this cycle |
| smp_data | input | 16 | Sample word |
| conv_fault | input | 1 | Converter hardware overrun strobe |
| host_wr | input | 1 | Host register write |
| host_rd | input | 1 | Host read request |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, one cycle after host_rd |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong front or rear index shows up in two places. A host read of the index returns the wrong value, and a storage read returns the wrong word, one cycle after the request. A wrong occupancy value moves the edge at which flag bit 0 sets. Because irq derives from registered flags, it shifts one cycle after the faulty pending value appears. A full detector that is off by one either sets the software overrun flag a sample early or lets the dropped sample overwrite the oldest unread slot. A later storage read exposes that overwrite.

// File: rtl/acqring_pkg.sv
package acqring_pkg;

    localparam int SAMPLE_W = 16;
    localparam int ADDR_W   = 12;
    localparam int FLAG_W   = 8;
    localparam int OWN_FLAGS = 3;

    localparam logic [ADDR_W-1:0] A_STORE_BASE = 12'h800;
    localparam logic [ADDR_W-1:0] A_THRESH     = 12'hff4;
    localparam logic [ADDR_W-1:0] A_FRONT      = 12'hff9;
    localparam logic [ADDR_W-1:0] A_REAR       = 12'hffa;
    localparam logic [ADDR_W-1:0] A_MASK       = 12'hffb;
    localparam logic [ADDR_W-1:0] A_FLAGS      = 12'hffc;

    localparam int FB_THRESH = 0;
    localparam int FB_SWERR  = 1;
    localparam int FB_HWERR  = 2;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STORE, SEL_FRONT, SEL_REAR, SEL_THRESH, SEL_MASK, SEL_FLAGS
    } rsel_e;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
        logic [SAMPLE_W-1:0] wdata;
    } host_req_t;

    function automatic rsel_e addr_decode(input logic [ADDR_W-1:0] a, input int depth);
        int ai;
        ai = int'(a);
        if (ai >= int'(A_STORE_BASE) && ai < int'(A_STORE_BASE) + depth) return SEL_STORE;
        case (a)
            A_FRONT:  return SEL_FRONT;
            A_REAR:   return SEL_REAR;
            A_THRESH: return SEL_THRESH;
            A_MASK:   return SEL_MASK;
            A_FLAGS:  return SEL_FLAGS;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ring_store.sv
module ring_store
    import acqring_pkg::*;
#(
    parameter int DEPTH = 2003,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IW-1:0]       waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic                re,
    input  logic [IW-1:0]       raddr,
    output logic [SAMPLE_W-1:0] q
);
    logic [SAMPLE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/ring_ptrs.sv
module ring_ptrs
    import acqring_pkg::*;
#(
    parameter int DEPTH = 2003,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic                rear_we,
    input  logic [SAMPLE_W-1:0] rear_req,
    output logic [IW-1:0]       front,
    output logic [IW-1:0]       rear,
    output logic [IW-1:0]       pending,
    output logic                full,
    output logic                accept
);
    localparam logic [IW:0]   DEPTH_V = (IW+1)'(DEPTH);
    localparam logic [IW-1:0] LAST    = IW'(DEPTH - 1);

    logic [IW:0] span;

    always_comb begin
        if (front >= rear) span = {1'b0, front} - {1'b0, rear};
        else               span = {1'b0, front} + DEPTH_V - {1'b0, rear};
        pending = span[IW-1:0];
        full    = (pending == LAST);
        accept  = push && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front <= '0;
            rear  <= '0;
        end else begin
            if (accept) front <= (front == LAST) ? '0 : front + 1'b1;
            if (rear_we && int'(rear_req) < DEPTH) rear <= rear_req[IW-1:0];
        end
    end

    p_front_range_r2: assert property (@(posedge clk) disable iff (rst)
        int'(front) < DEPTH && int'(rear) < DEPTH);
    p_front_move_r2: assert property (@(posedge clk) disable iff (rst)
        accept |=> front != $past(front));
    p_drop_full_r4: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(front));
    p_rear_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (rear_we && int'(rear_req) >= DEPTH) |=> $stable(rear));
endmodule

// File: rtl/ring_flags.sv
module ring_flags
    import acqring_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OWN_FLAGS-1:0] set_i,
    input  logic                 clr_we,
    input  logic [OWN_FLAGS-1:0] clr_i,
    input  logic                 mask_we,
    input  logic [FLAG_W-1:0]    mask_i,
    output logic [FLAG_W-1:0]    flags_o,
    output logic [FLAG_W-1:0]    mask_o,
    output logic                 irq
);
    logic [OWN_FLAGS-1:0] f;

    for (genvar b = 0; b < OWN_FLAGS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           f[b] <= 1'b0;
            else if (set_i[b]) f[b] <= 1'b1;
            else if (clr_we && clr_i[b]) f[b] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_o <= '0;
        else if (mask_we) mask_o <= mask_i;
    end

    assign flags_o = {{(FLAG_W-OWN_FLAGS){1'b0}}, f};
    assign irq     = |(flags_o & mask_o);

    p_mask_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (mask_o == '0) |-> !irq);
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        flags_o[FLAG_W-1:OWN_FLAGS] == '0);
endmodule

// File: rtl/acq_ring_buffer.sv
module acq_ring_buffer
    import acqring_pkg::*;
#(
    parameter int DEPTH = 2003,
    parameter int THRESH_RST = DEPTH / 2,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                conv_fault,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [SAMPLE_W-1:0] host_wdata,
    output logic [SAMPLE_W-1:0] host_rdata,
    output logic                irq
);
    host_req_t req;
    rsel_e     sel, rsel_q;

    logic [IW-1:0]       front, rear, pending, thresh, st_raddr;
    logic                full, accept;
    logic [FLAG_W-1:0]   flags, mask;
    logic [OWN_FLAGS-1:0] set_v;
    logic [SAMPLE_W-1:0] st_q, reg_q;
    logic [ADDR_W-1:0]   offs;

    assign req = '{wr: host_wr, rd: host_rd, addr: host_addr, wdata: host_wdata};
    assign sel = addr_decode(req.addr, DEPTH);
    assign offs = req.addr - A_STORE_BASE;
    assign st_raddr = offs[IW-1:0];

    ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .push(smp_valid),
        .rear_we(req.wr && sel == SEL_REAR), .rear_req(req.wdata),
        .front(front), .rear(rear), .pending(pending),
        .full(full), .accept(accept)
    );

    ring_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(accept), .waddr(front), .wdata(smp_data),
        .re(req.rd && sel == SEL_STORE), .raddr(st_raddr), .q(st_q)
    );

    always_comb begin
        set_v            = '0;
        set_v[FB_THRESH] = (pending >= thresh);
        set_v[FB_SWERR]  = smp_valid && full;
        set_v[FB_HWERR]  = conv_fault;
    end

    ring_flags u_flags (
        .clk(clk), .rst(rst), .set_i(set_v),
        .clr_we(req.wr && sel == SEL_FLAGS), .clr_i(req.wdata[OWN_FLAGS-1:0]),
        .mask_we(req.wr && sel == SEL_MASK), .mask_i(req.wdata[FLAG_W-1:0]),
        .flags_o(flags), .mask_o(mask), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst)                                thresh <= IW'(THRESH_RST);
        else if (req.wr && sel == SEL_THRESH)   thresh <= req.wdata[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel_q <= SEL_NONE;
            reg_q  <= '0;
        end else if (req.rd) begin
            rsel_q <= sel;
            case (sel)
                SEL_FRONT:  reg_q <= SAMPLE_W'(front);
                SEL_REAR:   reg_q <= SAMPLE_W'(rear);
                SEL_THRESH: reg_q <= SAMPLE_W'(thresh);
                SEL_MASK:   reg_q <= SAMPLE_W'(mask);
                SEL_FLAGS:  reg_q <= SAMPLE_W'(flags);
                default:    reg_q <= '0;
            endcase
        end
    end

    assign host_rdata = (rsel_q == SEL_STORE) ? st_q : reg_q;

    p_swerr_set_r4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && full) |=> flags[FB_SWERR]);
    p_hwerr_set_r5: assert property (@(posedge clk) disable iff (rst)
        conv_fault |=> flags[FB_HWERR]);
    p_thresh_set_r7: assert property (@(posedge clk) disable iff (rst)
        (pending >= thresh) |=> flags[FB_THRESH]);
    p_pending_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(pending) < DEPTH);
endmodule

// File: tb/acq_ring_buffer_test.sv
module acq_ring_buffer_test;
    localparam int DEPTH = 2003;

    logic        clk = 0;
    logic        rst = 1;
    logic        smp_valid = 0, conv_fault = 0, host_wr = 0, host_rd = 0;
    logic [15:0] smp_data = 0, host_wdata = 0;
    logic [11:0] host_addr = 0;
    logic [15:0] host_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acq_ring_buffer uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .conv_fault(conv_fault), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    // behavioural reference
    int m_mem [DEPTH];
    int m_front, m_rear, m_thr, m_mask, m_flags, m_rdata, m_last_addr;

    function automatic int pend(int f, int r);
        int d;
        d = f - r;
        if (d < 0) d += DEPTH;
        return d;
    endfunction

    function automatic int rd_value(int a);
        if (a >= 'h800 && a < 'h800 + DEPTH) return m_mem[a - 'h800];
        case (a)
            'hff9: return m_front;
            'hffa: return m_rear;
            'hff4: return m_thr;
            'hffb: return m_mask;
            'hffc: return m_flags;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        if (a >= 'h800 && a < 'h800 + DEPTH) return "R2";
        case (a)
            'hff9: return "R2";
            'hffa: return "R6";
            'hff4: return "R7";
            'hffb: return "R9";
            'hffc: return "R8";
            default: return "R10";
        endcase
    endfunction

    initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_front = 0; m_rear = 0; m_thr = DEPTH / 2; m_mask = 0;
            m_flags = 0; m_rdata = 0; m_last_addr = 0;
        end else begin
            int p, s, clr;
            p = pend(m_front, m_rear);
            if (host_rd) begin
                m_rdata = rd_value(int'(host_addr));
                m_last_addr = int'(host_addr);
            end
            s = 0;
            if (p >= m_thr) s |= 1;
            if (smp_valid && p == DEPTH - 1) s |= 2;
            if (conv_fault) s |= 4;
            if (smp_valid && p < DEPTH - 1) begin
                m_mem[m_front] = int'(smp_data);
                m_front = (m_front == DEPTH - 1) ? 0 : m_front + 1;
            end
            clr = 0;
            if (host_wr) begin
                case (int'(host_addr))
                    'hffa: if (int'(host_wdata) < DEPTH) m_rear = int'(host_wdata);
                    'hff4: m_thr = int'(host_wdata) & 'h7ff;
                    'hffb: m_mask = int'(host_wdata) & 'hff;
                    'hffc: clr = int'(host_wdata) & 7;
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | s;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq !== ((m_flags & m_mask) != 0)) begin
                fails++;
                $display("FAIL R9 irq actual=%0b expected=%0b", irq, (m_flags & m_mask) != 0);
            end
            checks++;
            if (int'(host_rdata) != m_rdata) begin
                fails++;
                $display("FAIL %s rdata addr=%h actual=%h expected=%h",
                         tag_of(m_last_addr), m_last_addr, host_rdata, m_rdata);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic hr(input logic [11:0] a, output int v);
        @(negedge clk); host_rd = 1; host_addr = a;
        @(negedge clk); host_rd = 0; v = int'(host_rdata);
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        hr(12'hff9, v); chk(v, 0, "R1 front");
        hr(12'hffa, v); chk(v, 0, "R1 rear");
        hr(12'hffb, v); chk(v, 0, "R1 mask");
        hr(12'hffc, v); chk(v, 0, "R1 flags");
        hr(12'hff4, v); chk(v, 1001, "R1 threshold");
        chk(int'(irq), 0, "R1 irq");
        // R2 storage and front
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); smp_valid = 1; smp_data = 16'hA000 + 16'(i);
        end
        @(negedge clk); smp_valid = 0;
        hr(12'h802, v); chk(v, 'hA002, "R2 stored word");
        hr(12'hff9, v); chk(v, 5, "R2 front");
        // R10 read-only window and unmapped
        hw(12'h800, 16'h1234);
        hr(12'h800, v); chk(v, 'hA000, "R10 store read-only");
        hr(12'h7ff, v); chk(v, 0, "R10 unmapped");
        // R7 / R9 threshold interrupt
        hw(12'hff4, 16'd4);
        hw(12'hffb, 16'h0001);
        @(negedge clk);
        chk(int'(irq), 1, "R9 irq on threshold");
        hw(12'hffc, 16'h0001);
        hr(12'hffc, v); chk(v & 1, 1, "R7 set beats clear");
        hw(12'hffa, 16'd5);
        hw(12'hffc, 16'h0001);
        hr(12'hffc, v); chk(v, 0, "R8 w1c clears");
        chk(int'(irq), 0, "R9 irq drops");
        hw(12'hffc, 16'h00f8);
        hr(12'hffc, v); chk(v, 0, "R8 upper bits zero");
        // R6 out-of-range rear ignored
        hw(12'hffa, 16'd2003);
        hw(12'hffa, 16'd3000);
        hr(12'hffa, v); chk(v, 5, "R6 rear ignore");
        // R4 fill to DEPTH-1 then overrun
        hw(12'hff4, 16'h07ff);
        for (int j = 0; j < DEPTH - 1; j++) begin
            @(negedge clk); smp_valid = 1; smp_data = 16'(j) ^ 16'h5A5A;
        end
        @(negedge clk); smp_valid = 0;
        hr(12'hffc, v); chk(v & 2, 0, "R4 no overrun yet");
        @(negedge clk); smp_valid = 1; smp_data = 16'hDEAD;
        @(negedge clk); smp_valid = 0;
        hr(12'hff9, v); chk(v, 4, "R4 front held");
        hr(12'hffc, v); chk(v & 2, 2, "R4 sw overrun flag");
        hr(12'h804, v); chk(v, 'hA004, "R4 dropped not stored");
        hr(12'h800, v); chk(v, 16'(1998) ^ 'h5A5A, "R2 wrapped store");
        // R3 negative difference, R6 rear effect next clock
        hw(12'hffc, 16'h0007);
        hw(12'hffa, 16'd1000);
        hw(12'hff4, 16'd1008);
        @(negedge clk);
        hr(12'hffc, v); chk(v & 1, 0, "R3 pending 1007 below 1008");
        hw(12'hff4, 16'd1007);
        @(negedge clk);
        hr(12'hffc, v); chk(v & 1, 1, "R3 pending 1007 reaches 1007");
        // R5 hardware fault and R9 mask gating
        hw(12'hffb, 16'h0000);
        @(negedge clk); conv_fault = 1;
        @(negedge clk); conv_fault = 0;
        hr(12'hffc, v); chk(v & 4, 4, "R5 hw overrun flag");
        chk(int'(irq), 0, "R9 mask zero blocks");
        hw(12'hffb, 16'h0004);
        @(negedge clk);
        chk(int'(irq), 1, "R9 mask selects hw flag");
        hw(12'hffc, 16'h0004);
        hr(12'hffc, v); chk(v & 4, 0, "R8 clear hw flag");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule